// File: doc/BRIEF.md
# SPI Receive Status and Interrupt Unit

This unit holds the receive-side status of a serial peripheral interface controller and turns it into interrupt requests. The shift logic sends it a one-cycle pulse and a byte each time a receive completes. The slave-select logic sends it a mode-fault detect pulse. The bus decoder sends it one-cycle strobes for reads of the status register and of the data register. The unit keeps one byte of receive data and three flags: receiver full, overrun and mode fault.

A flag clears only through a two-step read. First a status read must return the flag as 1, which arms that flag. Then a data read clears every armed flag. A flag that sets after the status read is not armed, so the next data read leaves it set. When a byte arrives while the receiver is still full, the byte is dropped, the held byte stays in the data register, and the overrun flag sets. All three conditions feed one shared receiver/error interrupt. The transmitter-empty input drives a separate transmitter interrupt.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, `stat_q` is 0 and both interrupt outputs are low. The field layout of `stat_q` is: bit 0 = receiver full, bit 1 = overrun, bit 2 = mode fault.
- R2: A `rx_done` pulse while receiver full is 0 loads `rx_byte` into `data_q` and sets `stat_q[0]` on the next cycle.
- R3: A `rx_done` pulse while receiver full is 1, with no clearing data read in the same cycle, sets `stat_q[1]`. `data_q` keeps the earlier byte.
- R4: Receiver full clears only on a `data_rd` that follows a `stat_rd` which returned `stat_q[0]` as 1. A data read with no such status read leaves the flag set.
- R5: Overrun clears on a `data_rd` that follows a `stat_rd` which returned `stat_q[1]` as 1. That data read returns the byte held before the lost byte.
- R6: A flag that sets after the arming status read is not cleared by the next data read. Each data read uses up the armed state.
- R7: Mode fault sets on `modf_detect` only while `modf_en` is 1.
- R8: Driving `modf_en` to 0 leaves a set mode-fault flag set. Once that flag is cleared by the two-step read, it stays clear while `modf_en` is 0.
- R9: `irq_rxerr` is 1 exactly when `spi_en` is 1 and either (`rx_ie` and receiver full) or (`err_ie` and (overrun or mode fault)).
- R10: `irq_tx` equals `spi_en & tx_ie & tx_empty`.
- R11: While `spi_en` is 0, all flags are held at 0, `rx_done` has no effect on `stat_q`, and both interrupts are low.
- R12: When `rx_done` and a clearing `data_rd` fall in the same cycle, the clear happens first. The new byte is then loaded, receiver full reads 1 on the next cycle, and overrun does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_en | input | 1 | Peripheral enable |
| rx_ie | input | 1 | Enables the receiver-full interrupt |
| err_ie | input | 1 | Enables the overrun and mode-fault interrupts |
| tx_ie | input | 1 | Enables the transmitter interrupt |
| modf_en | input | 1 | Enables setting of the mode-fault flag |
| tx_empty | input | 1 | Transmitter-empty flag |
| rx_done | input | 1 | Receive-complete pulse |
| rx_byte | input | DATA_W | Received byte |
| modf_detect | input | 1 | Mode-fault detect pulse |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| stat_q | output | 3 | Status: {mode fault, overrun, receiver full} |
| data_q | output | DATA_W | Receive data register |
| irq_rxerr | output | 1 | Shared receiver/error interrupt |
| irq_tx | output | 1 | Transmitter interrupt |

## Verification
The hardest state to reach is a mix of armed and unarmed flags. This happens when an overrun sets after a status read has already armed receiver full, so the following data read clears one flag and leaves the other set. The vector table reaches this with the sequence receive, status read, receive, data read, and checks `stat_q` after each step. A second sequence places a receive in the same cycle as a clearing data read, which exercises the rule that the clear happens first.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
  localparam int unsigned NFLAG    = 3;
  localparam int unsigned FL_FULL  = 0;
  localparam int unsigned FL_OVR   = 1;
  localparam int unsigned FL_MODF  = 2;

  function automatic logic rxerr_req(input logic en, input logic rie,
                                     input logic eie, input logic [NFLAG-1:0] f);
    return en & ((rie & f[FL_FULL]) | (eie & (f[FL_OVR] | f[FL_MODF])));
  endfunction

  function automatic logic tx_req(input logic en, input logic tie, input logic te);
    return en & tie & te;
  endfunction
endpackage

// File: rtl/spi_rxs_flag.sv
module spi_rxs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_i,
  input  logic rd_stat,
  input  logic rd_data,
  output logic flag_o,
  output logic arm_o,
  output logic clr_o
);
  logic flag_q, arm_q;

  assign clr_o  = rd_data & arm_q;
  assign flag_o = flag_q;
  assign arm_o  = arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (!en) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr_o);
      if (rd_stat)      arm_q <= flag_q & ~clr_o;
      else if (rd_data) arm_q <= 1'b0;
    end
  end

  // R6: a set but unarmed flag survives any data read
  p_unarmed_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flag_q && !arm_q) |=> flag_q);

  // R4: a flag can only fall after a data read or a disable
  p_clear_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flag_q && !rd_data) |=> flag_q);
endmodule

// File: rtl/spi_rxs_rxbuf.sv
module spi_rxs_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              full,
  input  logic              full_clr,
  output logic [DATA_W-1:0] data_o,
  output logic              load_o,
  output logic              lost_o
);
  logic [DATA_W-1:0] data_q;

  assign load_o = en & rx_done & (~full | full_clr);
  assign lost_o = en & rx_done & full & ~full_clr;
  assign data_o = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_o) data_q <= rx_byte;
  end

  // R3: a dropped byte never disturbs the held byte
  p_lost_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |=> $stable(data_q));

  // R2: an accepted byte appears in the register
  p_load_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (data_q == $past(rx_byte)));
endmodule

// File: rtl/spi_rxs_irq.sv
module spi_rxs_irq
  import spi_rxs_pkg::*;
(
  input  logic             en,
  input  logic             rx_ie,
  input  logic             err_ie,
  input  logic             tx_ie,
  input  logic             tx_empty,
  input  logic [NFLAG-1:0] flags,
  output logic             irq_rxerr,
  output logic             irq_tx
);
  assign irq_rxerr = rxerr_req(en, rx_ie, err_ie, flags);
  assign irq_tx    = tx_req(en, tx_ie, tx_empty);

  // R9: without an error enable, errors alone raise nothing
  always_comb begin
    if (en && !err_ie && !(rx_ie && flags[FL_FULL]))
      a_err_gated_r9: assert (!irq_rxerr);
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_en,
  input  logic              rx_ie,
  input  logic              err_ie,
  input  logic              tx_ie,
  input  logic              modf_en,
  input  logic              tx_empty,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              modf_detect,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [2:0]        stat_q,
  output logic [DATA_W-1:0] data_q,
  output logic              irq_rxerr,
  output logic              irq_tx
);
  logic [NFLAG-1:0] set_v, flag_v, arm_v, clr_v;
  logic             rx_load, rx_lost, modf_set;

  assign modf_set = spi_en & modf_en & modf_detect;

  always_comb begin
    set_v          = '0;
    set_v[FL_FULL] = rx_load;
    set_v[FL_OVR]  = rx_lost;
    set_v[FL_MODF] = modf_set;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_rxs_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (spi_en),
      .set_i   (set_v[g]),
      .rd_stat (stat_rd),
      .rd_data (data_rd),
      .flag_o  (flag_v[g]),
      .arm_o   (arm_v[g]),
      .clr_o   (clr_v[g])
    );
  end

  spi_rxs_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (spi_en),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte),
    .full     (flag_v[FL_FULL]),
    .full_clr (clr_v[FL_FULL]),
    .data_o   (data_q),
    .load_o   (rx_load),
    .lost_o   (rx_lost)
  );

  spi_rxs_irq u_irq (
    .en        (spi_en),
    .rx_ie     (rx_ie),
    .err_ie    (err_ie),
    .tx_ie     (tx_ie),
    .tx_empty  (tx_empty),
    .flags     (flag_v),
    .irq_rxerr (irq_rxerr),
    .irq_tx    (irq_tx)
  );

  assign stat_q = flag_v;

  // R12: receive colliding with a clearing read leaves full set, no overrun
  p_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && rx_done && data_rd && arm_v[FL_FULL]) |=> (stat_q[FL_FULL] && !rx_lost));

  // R7: mode fault cannot rise without its enable
  p_modf_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[FL_MODF] && !modf_en) |=> !stat_q[FL_MODF]);

  // R11: disabled peripheral shows no flags
  p_off_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |=> (stat_q == '0));

  // R3: overrun follows a receive into a full, uncleared buffer
  p_ovr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && rx_done && stat_q[FL_FULL] && !data_rd) |=> stat_q[FL_OVR]);
endmodule

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_en = 1'b0, rx_ie = 1'b0, err_ie = 1'b0, tx_ie = 1'b0;
  logic modf_en = 1'b0, tx_empty = 1'b0, rx_done = 1'b0, modf_detect = 1'b0;
  logic stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [2:0] stat_q;
  logic [7:0] data_q;
  logic irq_rxerr, irq_tx;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  spi_rx_status u_dut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .rx_ie(rx_ie), .err_ie(err_ie),
    .tx_ie(tx_ie), .modf_en(modf_en), .tx_empty(tx_empty), .rx_done(rx_done),
    .rx_byte(rx_byte), .modf_detect(modf_detect), .stat_rd(stat_rd),
    .data_rd(data_rd), .stat_q(stat_q), .data_q(data_q),
    .irq_rxerr(irq_rxerr), .irq_tx(irq_tx)
  );

  // vector: {rx_done, stat_rd, data_rd, byte[7:0], exp_stat[2:0], exp_data[7:0], req[7:0]}
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {3'b100, 8'hA5, 3'b001, 8'hA5, 8'd2},   // R2 load
    {3'b001, 8'h00, 3'b001, 8'hA5, 8'd4},   // R4 data read without status read
    {3'b100, 8'h3C, 3'b011, 8'hA5, 8'd3},   // R3 overrun keeps A5
    {3'b010, 8'h00, 3'b011, 8'hA5, 8'd5},   // arm both
    {3'b001, 8'h00, 3'b000, 8'hA5, 8'd5},   // R5 clear returns older byte
    {3'b100, 8'h11, 3'b001, 8'h11, 8'd2},
    {3'b010, 8'h00, 3'b001, 8'h11, 8'd4},   // arm full only
    {3'b100, 8'h22, 3'b011, 8'h11, 8'd3},   // overrun after status read
    {3'b001, 8'h00, 3'b010, 8'h11, 8'd6},   // R6 overrun not armed
    {3'b010, 8'h00, 3'b010, 8'h11, 8'd6},
    {3'b001, 8'h00, 3'b000, 8'h11, 8'd5},
    {3'b100, 8'h44, 3'b001, 8'h44, 8'd2},
    {3'b010, 8'h00, 3'b001, 8'h44, 8'd12},
    {3'b101, 8'h55, 3'b001, 8'h55, 8'd12},  // R12 collide
    {3'b001, 8'h00, 3'b001, 8'h55, 8'd6},   // arm used up
    {3'b010, 8'h00, 3'b001, 8'h55, 8'd4},
    {3'b001, 8'h00, 3'b000, 8'h55, 8'd4}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic rd, input logic sr, input logic dr,
                       input logic [7:0] b, input logic md);
    @(negedge clk);
    rx_done = rd; stat_rd = sr; data_rd = dr; rx_byte = b; modf_detect = md;
    @(posedge clk);
    #1;
    rx_done = 1'b0; stat_rd = 1'b0; data_rd = 1'b0; modf_detect = 1'b0;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(stat_q == 3'b000, "R1 stat", stat_q, 0);
    chk(!irq_rxerr && !irq_tx, "R1 irq", {irq_rxerr, irq_tx}, 0);
    rst_n = 1'b1;
    spi_en = 1'b1; modf_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      pulse(v[29], v[28], v[27], v[26:19], 1'b0);
      chk(stat_q == v[18:16], $sformatf("R%0d stat vec%0d", v[7:0], i), stat_q, v[18:16]);
      chk(data_q == v[15:8], $sformatf("R%0d data vec%0d", v[7:0], i), data_q, v[15:8]);
    end

    // R7: mode fault gated by its enable
    modf_en = 1'b0;
    pulse(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    chk(stat_q[2] == 1'b0, "R7 gated", stat_q, 0);
    modf_en = 1'b1;
    pulse(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    chk(stat_q == 3'b100, "R7 set", stat_q, 3'b100);
    // R8: enable low keeps the flag
    modf_en = 1'b0;
    pulse(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(stat_q == 3'b100, "R8 keep", stat_q, 3'b100);
    // R9: error interrupt gating
    err_ie = 1'b0; rx_ie = 1'b1; #1;
    chk(irq_rxerr == 1'b0, "R9 err off", irq_rxerr, 0);
    err_ie = 1'b1; #1;
    chk(irq_rxerr == 1'b1, "R9 err on", irq_rxerr, 1);
    pulse(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    pulse(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    chk(stat_q == 3'b000, "R8 cleared", stat_q, 0);
    pulse(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    chk(stat_q == 3'b000, "R8 no reset", stat_q, 0);
    chk(irq_rxerr == 1'b0, "R9 idle", irq_rxerr, 0);
    // R9: receiver full with rx_ie
    err_ie = 1'b0;
    pulse(1'b1, 1'b0, 1'b0, 8'h66, 1'b0);
    chk(irq_rxerr == 1'b1, "R9 full on", irq_rxerr, 1);
    rx_ie = 1'b0; #1;
    chk(irq_rxerr == 1'b0, "R9 full off", irq_rxerr, 0);
    // R10: transmitter interrupt
    tx_empty = 1'b1; tx_ie = 1'b0; #1;
    chk(irq_tx == 1'b0, "R10 off", irq_tx, 0);
    tx_ie = 1'b1; #1;
    chk(irq_tx == 1'b1, "R10 on", irq_tx, 1);
    // R11: disable clears and blocks
    rx_ie = 1'b1; err_ie = 1'b1;
    spi_en = 1'b0; #1;
    chk(!irq_rxerr && !irq_tx, "R11 irq", {irq_rxerr, irq_tx}, 0);
    pulse(1'b1, 1'b0, 1'b0, 8'h77, 1'b0);
    chk(stat_q == 3'b000, "R11 stat", stat_q, 0);
    spi_en = 1'b1;
    pulse(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(stat_q == 3'b000, "R11 rx ignored", stat_q, 0);
    // R1: reset again mid-run
    pulse(1'b1, 1'b0, 1'b0, 8'h88, 1'b0);
    rst_n = 1'b0; #1;
    chk(stat_q == 3'b000, "R1 re-reset", stat_q, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule